// File: doc/BRIEF.md
# Subtract and Test Flag Unit

This block is the arithmetic slice of an 8-bit accumulator core that carries out two instruction families: subtract-from-accumulator and test-for-negative-or-zero. The sequencer hands it a decoded opcode byte, a flag that marks a preceding extension (prebyte) byte, the accumulator, the low byte of the index register, a memory operand that is already fetched, and the current six-bit condition code register. When `exec` is high, the unit registers a new accumulator, new condition codes, the instruction's cycle count for its addressing mode, and an illegal-opcode flag. All of these appear one clock later, together with a one-cycle `done_o` pulse.

Subtract writes the difference back to the accumulator and updates overflow, negative, zero and borrow. It leaves half-carry and the interrupt mask as they were. Test stores nothing. It clears overflow, sets negative and zero from the tested byte, and keeps half-carry, the mask and borrow. An opcode the unit does not recognise passes the accumulator and the flags through unchanged and raises `illegal_o`.

Top module: `sub_tst_unit`

## Requirements
- R1: After reset, `acc_o`=0x00, `ccr_o`=6'b001000 (only the mask set), `cyc_o`=0, `illegal_o`=0 and `done_o`=0. The flag bit positions of `ccr_o` and `ccr_in` are: bit5 overflow V, bit4 half-carry H, bit3 interrupt mask I, bit2 negative N, bit1 zero Z, bit0 borrow C.
- R2: A subtract registers `acc_o` = (`a_in` − `mem_in`) mod 256 on the clock edge where `exec` is high. `done_o` is high in the following cycle.
- R3: For a subtract, V = 1 exactly when `a_in` and `mem_in` differ in bit 7 and bit 7 of the result differs from bit 7 of `a_in`.
- R4: For a subtract, C = 1 exactly when `mem_in` > `a_in` as unsigned values.
- R5: For both operations, N equals bit 7 of the result (for test, the tested byte), and Z = 1 exactly when that byte is zero.
- R6: A subtract copies H and I from `ccr_in` unchanged.
- R7: A test sets V = 0, copies H, I and C from `ccr_in`, and returns `acc_o` = `a_in`.
- R8: The byte a test examines depends on the opcode: 0x4D takes `a_in`, 0x5D takes `x_in`, and 0x3D, 0x6D, 0x7D and prebyte+0x6D take `mem_in`.
- R9: Subtract opcodes and their cycle counts are: 0xA0 → 2, 0xB0 → 3, 0xC0 → 4, 0xD0 → 4, 0xE0 → 3, 0xF0 → 2, prebyte+0xE0 → 4, prebyte+0xD0 → 5.
- R10: Test opcode cycle counts are: 0x3D → 3, 0x4D → 1, 0x5D → 1, 0x6D → 3, 0x7D → 2, prebyte+0x6D → 4.
- R11: Any other combination of `pre` and `opcode` gives `illegal_o`=1, `cyc_o`=0, `acc_o`=`a_in` and `ccr_o`=`ccr_in`.
- R12: While `exec` is low, `acc_o`, `ccr_o`, `cyc_o` and `illegal_o` hold their values and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Execute the presented instruction |
| pre | input | 1 | Opcode was preceded by the extension prebyte |
| opcode | input | 8 | Decoded opcode byte |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Index register low byte |
| mem_in | input | 8 | Resolved memory operand |
| ccr_in | input | 6 | Current condition codes {V,H,I,N,Z,C} |
| acc_o | output | 8 | New accumulator |
| ccr_o | output | 6 | New condition codes {V,H,I,N,Z,C} |
| cyc_o | output | 3 | Cycle count of the executed instruction |
| illegal_o | output | 1 | Opcode was not recognised |
| done_o | output | 1 | Outputs were updated in the previous edge |

## Verification
Signed overflow and unsigned borrow come from the same subtraction and can both be set in one result. The bench provokes this directly with 0x7F − 0xFF, which gives 0x80 with V=1 and C=1, and it separates the two with 0x80 − 0x01 (V only) and 0x00 − 0x01 (C only). Random operand pairs then mix both kinds of outcome. A bench model computes each flag independently from the signs and the unsigned magnitudes, and every flag bit is compared one cycle after `exec`.

// File: rtl/sub_tst_unit.sv
module sub_tst_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic       pre,
  input  logic [7:0] opcode,
  input  logic [7:0] a_in,
  input  logic [7:0] x_in,
  input  logic [7:0] mem_in,
  input  logic [5:0] ccr_in,
  output logic [7:0] acc_o,
  output logic [5:0] ccr_o,
  output logic [2:0] cyc_o,
  output logic       illegal_o,
  output logic       done_o
);
  localparam int FV = 5, FH = 4, FI = 3, FN = 2, FZ = 1, FC = 0;
  localparam logic [5:0] CCR_RST = 6'b001000;

  logic       is_sub, is_tst;
  logic [1:0] src;
  logic [2:0] cyc;

  always_comb begin
    is_sub = 1'b0;
    is_tst = 1'b0;
    src    = 2'd0;
    cyc    = 3'd0;
    case ({pre, opcode})
      9'h0A0: begin is_sub = 1'b1; cyc = 3'd2; end
      9'h0B0: begin is_sub = 1'b1; cyc = 3'd3; end
      9'h0C0: begin is_sub = 1'b1; cyc = 3'd4; end
      9'h0D0: begin is_sub = 1'b1; cyc = 3'd4; end
      9'h0E0: begin is_sub = 1'b1; cyc = 3'd3; end
      9'h0F0: begin is_sub = 1'b1; cyc = 3'd2; end
      9'h1E0: begin is_sub = 1'b1; cyc = 3'd4; end
      9'h1D0: begin is_sub = 1'b1; cyc = 3'd5; end
      9'h03D: begin is_tst = 1'b1; cyc = 3'd3; end
      9'h04D: begin is_tst = 1'b1; cyc = 3'd1; src = 2'd1; end
      9'h05D: begin is_tst = 1'b1; cyc = 3'd1; src = 2'd2; end
      9'h06D: begin is_tst = 1'b1; cyc = 3'd3; end
      9'h07D: begin is_tst = 1'b1; cyc = 3'd2; end
      9'h16D: begin is_tst = 1'b1; cyc = 3'd4; end
      default: ;
    endcase
  end

  wire [7:0] tst_byte = (src == 2'd1) ? a_in : (src == 2'd2) ? x_in : mem_in;
  wire [8:0] diff     = {1'b0, a_in} - {1'b0, mem_in};
  wire [7:0] res      = is_sub ? diff[7:0] : tst_byte;
  wire       ovf      = (a_in[7] ^ mem_in[7]) & (diff[7] ^ a_in[7]);

  logic [5:0] ccr_n;
  always_comb begin
    ccr_n = ccr_in;
    if (is_sub || is_tst) begin
      ccr_n[FN] = res[7];
      ccr_n[FZ] = (res == 8'h00);
      ccr_n[FV] = is_sub & ovf;
      if (is_sub) ccr_n[FC] = diff[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o     <= 8'h00;
      ccr_o     <= CCR_RST;
      cyc_o     <= 3'd0;
      illegal_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= exec;
      if (exec) begin
        acc_o     <= is_sub ? diff[7:0] : a_in;
        ccr_o     <= ccr_n;
        cyc_o     <= cyc;
        illegal_o <= ~(is_sub | is_tst);
      end
    end
  end

  wire unused_fi_fh = (FI == FH);
endmodule

module sub_tst_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic       pre,
  input logic [7:0] opcode,
  input logic [7:0] a_in,
  input logic [7:0] mem_in,
  input logic [5:0] ccr_in,
  input logic [7:0] acc_o,
  input logic [5:0] ccr_o,
  input logic [2:0] cyc_o,
  input logic       illegal_o,
  input logic       done_o
);
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> done_o);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> (!done_o && $stable(acc_o) && $stable(ccr_o) && $stable(cyc_o) && $stable(illegal_o)));
  a_r4_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !pre && opcode == 8'hA0) |=> (ccr_o[0] == ($past(mem_in) > $past(a_in))));
  a_r6_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !pre && opcode == 8'hA0) |=> (ccr_o[4:3] == $past(ccr_in[4:3])));
  a_r7_test_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !pre && opcode == 8'h4D) |=> (!ccr_o[5] && acc_o == $past(a_in) && ccr_o[0] == $past(ccr_in[0])));
  a_r11_illegal_zero_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> (cyc_o == 3'd0));
  a_r9_sub_ext_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !pre && opcode == 8'hC0) |=> (cyc_o == 3'd4));
endmodule

bind sub_tst_unit sub_tst_unit_chk u_chk (.*);

// File: tb/tb_sub_tst_unit.sv
module tb_sub_tst_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, exec = 1'b0, pre = 1'b0;
  logic [7:0] opcode = 8'h00, a_in = 8'h00, x_in = 8'h00, mem_in = 8'h00;
  logic [5:0] ccr_in = 6'h00;
  logic [7:0] acc_o;
  logic [5:0] ccr_o;
  logic [2:0] cyc_o;
  logic illegal_o, done_o;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sub_tst_unit dut (.*);

  // {illegal, cyc[2:0], ccr[5:0], acc[7:0]}
  function automatic logic [17:0] model(input logic p, input logic [7:0] op, a, x, m,
                                        input logic [5:0] c);
    logic [7:0] r, t;
    logic [5:0] f;
    int cy;
    int kind;  // 0 illegal, 1 sub, 2 tst
    kind = 0; cy = 0; t = m;
    if (!p) begin
      case (op)
        8'hA0: begin kind = 1; cy = 2; end
        8'hB0: begin kind = 1; cy = 3; end
        8'hC0: begin kind = 1; cy = 4; end
        8'hD0: begin kind = 1; cy = 4; end
        8'hE0: begin kind = 1; cy = 3; end
        8'hF0: begin kind = 1; cy = 2; end
        8'h3D: begin kind = 2; cy = 3; end
        8'h4D: begin kind = 2; cy = 1; t = a; end
        8'h5D: begin kind = 2; cy = 1; t = x; end
        8'h6D: begin kind = 2; cy = 3; end
        8'h7D: begin kind = 2; cy = 2; end
        default: ;
      endcase
    end else begin
      case (op)
        8'hE0: begin kind = 1; cy = 4; end
        8'hD0: begin kind = 1; cy = 5; end
        8'h6D: begin kind = 2; cy = 4; end
        default: ;
      endcase
    end
    f = c;
    if (kind == 1) begin
      r = a - m;
      f[5] = (a[7] != m[7]) && (r[7] != a[7]);
      f[2] = r[7];
      f[1] = (r == 8'h00);
      f[0] = (m > a);
      return {1'b0, cy[2:0], f, r};
    end else if (kind == 2) begin
      f[5] = 1'b0;
      f[2] = t[7];
      f[1] = (t == 8'h00);
      return {1'b0, cy[2:0], f, a};
    end
    return {1'b1, 3'd0, c, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic p, input logic [7:0] op, a, x, m,
                     input logic [5:0] c);
    logic [17:0] e;
    e = model(p, op, a, x, m, c);
    pre = p; opcode = op; a_in = a; x_in = x; mem_in = m; ccr_in = c; exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
    check({req, " acc"}, {24'd0, acc_o}, {24'd0, e[7:0]});
    check({req, " ccr"}, {26'd0, ccr_o}, {26'd0, e[13:8]});
    check({req, " cyc"}, {29'd0, cyc_o}, {29'd0, e[16:14]});
    check({req, " illegal"}, {31'd0, illegal_o}, {31'd0, e[17]});
    check({req, " done"}, {31'd0, done_o}, 32'd1);
  endtask

  localparam logic [8:0] LEGAL [14] = '{9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, 9'h0E0, 9'h0F0,
    9'h1E0, 9'h1D0, 9'h03D, 9'h04D, 9'h05D, 9'h06D, 9'h07D, 9'h16D};

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] hacc;
    logic [5:0] hccr;
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1 acc", {24'd0, acc_o}, 32'h00);
    check("R1 ccr", {26'd0, ccr_o}, 32'h08);
    check("R1 cyc", {29'd0, cyc_o}, 32'd0);
    check("R1 illegal", {31'd0, illegal_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R4: overflow only, borrow only, both together
    run("R3 v only", 1'b0, 8'hA0, 8'h80, 8'h00, 8'h01, 6'h00);
    check("R3 v set", {31'd0, ccr_o[5]}, 32'd1);
    run("R4 c only", 1'b0, 8'hB0, 8'h00, 8'h00, 8'h01, 6'h00);
    check("R4 c set", {31'd0, ccr_o[0]}, 32'd1);
    run("R3 R4 both", 1'b0, 8'hC0, 8'h7F, 8'h00, 8'hFF, 6'h00);
    check("R3 R4 both flags", {30'd0, ccr_o[5], ccr_o[0]}, 32'd3);
    run("R5 zero", 1'b0, 8'hF0, 8'h55, 8'h00, 8'h55, 6'h3F);
    run("R6 keep HI", 1'b0, 8'hA0, 8'h10, 8'h00, 8'h20, 6'h18);
    run("R7 test clears v", 1'b0, 8'h3D, 8'h12, 8'h00, 8'h80, 6'h3F);
    run("R8 test acc", 1'b0, 8'h4D, 8'h00, 8'h80, 8'h80, 6'h00);
    run("R8 test x", 1'b0, 8'h5D, 8'h80, 8'h00, 8'h80, 6'h00);
    for (int i = 0; i < 14; i++)
      run("R9 R10 mode", LEGAL[i][8], LEGAL[i][7:0], 8'h40, 8'h01, 8'h41, 6'h15);
    run("R11 prebyte A0", 1'b1, 8'hA0, 8'h33, 8'h00, 8'h11, 6'h2A);
    run("R11 bad op", 1'b0, 8'h00, 8'h44, 8'h00, 8'h11, 6'h15);
    // R12: exec low with changing inputs
    run("R12 setup", 1'b0, 8'hA0, 8'h90, 8'h00, 8'h10, 6'h00);
    hacc = acc_o; hccr = ccr_o;
    pre = 1'b0; opcode = 8'hA0; a_in = 8'h01; mem_in = 8'h02; ccr_in = 6'h3F;
    repeat (3) @(negedge clk);
    check("R12 acc held", {24'd0, acc_o}, {24'd0, hacc});
    check("R12 ccr held", {26'd0, ccr_o}, {26'd0, hccr});
    check("R12 done low", {31'd0, done_o}, 32'd0);
    for (int i = 0; i < 400; i++) begin
      logic [8:0] pc;
      if ($urandom_range(0, 3) == 0) pc = 9'($urandom);
      else pc = LEGAL[$urandom_range(0, 13)];
      run("R2 R5 random", pc[8], pc[7:0], 8'($urandom), 8'($urandom), 8'($urandom), 6'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule